// File: doc/BRIEF.md
# Serial programming word decoder

This block accepts 21-bit programming words from a three-wire serial port made of a serial clock, a data line and a latch strobe. Bits enter most significant first on each rising serial clock edge. A rising edge on the latch strobe commits the collected word to one of four holding registers. The last two bits shifted in form a control pair, and that pair picks the target register.

The targets are the reference divider register, the N divider register and the function latch. The N divider register carries a fast-lock request bit, the prescaler-multiple count B and the swallow count A. An initialisation latch shares its fields with the function latch and also gives a one-cycle divider reset pulse. The decoder does not check whether the divider values are legal. It only flags a reference divider write whose reserved test bits are not zero.

The three serial pins are asynchronous to the system clock `clk`. They pass through synchronisers, and their edges are detected in the `clk` domain. The serial clock must therefore run well below `clk`.

Top module: `spw_decoder`

## Requirements
- R1: A word is 21 bits shifted MSB first. The first bit is field bit F19 and the last two are control bits C1 then C2. A reference divider ratio of 50 therefore appears as `r_div` = 50.
- R2: Control pair C1=0, C2=0 loads the reference register: `ld_prec` = F19 and `r_div` = F14..F1.
- R3: Control pair C1=1, C2=0 loads the N register: `n_go` = F19, `n_b` = F18..F6 and `n_a` = F5..F1.
- R4: Control pair C1=0, C2=1 loads the function latch: `func_word` = F19..F1, with F1 in bit 0. `cnt_hold` follows F1.
- R5: Control pair C1=1, C2=1 loads the same function fields and raises `div_rst` for exactly one `clk` cycle. A function latch write leaves `div_rst` low.
- R6: A load changes only the selected register. Shifting bits without a latch strobe edge changes no output.
- R7: A reference write with test bits F18..F15 not zero sets `r_test_err` and still loads `r_div` and `ld_prec`. A reference write with zero test bits clears `r_test_err`.
- R8: While reset is asserted, and after it is released, every output is zero until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; rising edge commits the word |
| ld_prec | output | 1 | Lock-detect precision flag |
| r_div | output | 14 | Reference divide ratio |
| r_test_err | output | 1 | Last reference write had nonzero test bits |
| n_go | output | 1 | Fast-lock request bit |
| n_b | output | 13 | B counter value |
| n_a | output | 5 | A counter value |
| func_word | output | 19 | Function latch fields F19..F1 |
| cnt_hold | output | 1 | Counter-reset hold (F1 of the function latch) |
| div_rst | output | 1 | One-cycle divider reset pulse on initialisation load |

## Verification
The hardest point to reach from the ports is isolation between targets. The bench has to show that a write to one register leaves the others untouched, and that a full word clocked in without a strobe edge does nothing. To get there, every register is first loaded with a distinct nonzero pattern. A word is then shifted in and its outputs are checked before the strobe is raised, and the unselected registers are checked again after it. The N register sweep walks every value of A against computed values of B. The reference register sweep walks a single one across the divider field. The test bit flag is first driven set and then driven clear.

// File: rtl/spw_pkg.sv
package spw_pkg;
  // Target select, encoded as {C1, C2} (C2 is the last bit shifted in)
  typedef enum logic [1:0] {
    SEL_R    = 2'b00,
    SEL_F    = 2'b01,
    SEL_N    = 2'b10,
    SEL_INIT = 2'b11
  } spw_sel_e;
endpackage

// File: rtl/spw_rst_sync.sv
module spw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/spw_in_sync.sv
module spw_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;
  logic [WIDTH-1:0]             prev_q;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], pins_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/spw_shifter.sv
module spw_shifter #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WORD_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/spw_router.sv
module spw_router
  import spw_pkg::*;
#(
  parameter int WORD_W = 21,
  parameter int CTRL_W = 2,
  parameter int RDIV_W = 14,
  parameter int TEST_W = 4,
  parameter int B_W    = 13,
  parameter int A_W    = 5,
  localparam int FIELD_W = WORD_W - CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               ld_prec_o,
  output logic [RDIV_W-1:0]  r_div_o,
  output logic               r_err_o,
  output logic               n_go_o,
  output logic [B_W-1:0]     n_b_o,
  output logic [A_W-1:0]     n_a_o,
  output logic [FIELD_W-1:0] func_o,
  output logic               div_rst_o
);
  logic [FIELD_W-1:0] fld;
  spw_sel_e           sel;

  assign fld = word_i[WORD_W-1:CTRL_W];
  assign sel = spw_sel_e'(word_i[1:0]);

  logic               ldp_q,  ldp_d;
  logic [RDIV_W-1:0]  rdiv_q, rdiv_d;
  logic               err_q,  err_d;
  logic               go_q,   go_d;
  logic [B_W-1:0]     b_q,    b_d;
  logic [A_W-1:0]     a_q,    a_d;
  logic [FIELD_W-1:0] func_q, func_d;
  logic               drst_q, drst_d;

  always_comb begin
    ldp_d  = ldp_q;
    rdiv_d = rdiv_q;
    err_d  = err_q;
    go_d   = go_q;
    b_d    = b_q;
    a_d    = a_q;
    func_d = func_q;
    drst_d = 1'b0;
    if (load_i) begin
      unique case (sel)
        SEL_R: begin
          ldp_d  = fld[FIELD_W-1];
          rdiv_d = fld[RDIV_W-1:0];
          err_d  = |fld[FIELD_W-2 -: TEST_W];
        end
        SEL_N: begin
          go_d = fld[FIELD_W-1];
          b_d  = fld[A_W +: B_W];
          a_d  = fld[A_W-1:0];
        end
        SEL_F: begin
          func_d = fld;
        end
        SEL_INIT: begin
          func_d = fld;
          drst_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldp_q  <= 1'b0;
      rdiv_q <= '0;
      err_q  <= 1'b0;
      go_q   <= 1'b0;
      b_q    <= '0;
      a_q    <= '0;
      func_q <= '0;
      drst_q <= 1'b0;
    end else begin
      ldp_q  <= ldp_d;
      rdiv_q <= rdiv_d;
      err_q  <= err_d;
      go_q   <= go_d;
      b_q    <= b_d;
      a_q    <= a_d;
      func_q <= func_d;
      drst_q <= drst_d;
    end
  end

  assign ld_prec_o = ldp_q;
  assign r_div_o   = rdiv_q;
  assign r_err_o   = err_q;
  assign n_go_o    = go_q;
  assign n_b_o     = b_q;
  assign n_a_o     = a_q;
  assign func_o    = func_q;
  assign div_rst_o = drst_q;
endmodule

// File: rtl/spw_decoder.sv
module spw_decoder #(
  parameter int WORD_W      = 21,
  parameter int CTRL_W      = 2,
  parameter int RDIV_W      = 14,
  parameter int TEST_W      = 4,
  parameter int B_W         = 13,
  parameter int A_W         = 5,
  parameter int SYNC_STAGES = 2,
  localparam int FIELD_W = WORD_W - CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  output logic               ld_prec,
  output logic [RDIV_W-1:0]  r_div,
  output logic               r_test_err,
  output logic               n_go,
  output logic [B_W-1:0]     n_b,
  output logic [A_W-1:0]     n_a,
  output logic [FIELD_W-1:0] func_word,
  output logic               cnt_hold,
  output logic               div_rst
);
  localparam int PIN_DATA = 0;
  localparam int PIN_CLK  = 1;
  localparam int PIN_LE   = 2;

  logic              rst_n_sync;
  logic [2:0]        pin_lvl;
  logic [2:0]        pin_rise;
  logic              shift_en;
  logic              le_rise;
  logic [WORD_W-1:0] word;

  spw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_sync)
  );

  spw_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .pins_i  ({ser_le, ser_clk, ser_data}),
    .level_o (pin_lvl),
    .rise_o  (pin_rise)
  );

  assign shift_en = pin_rise[PIN_CLK];
  assign le_rise  = pin_rise[PIN_LE];

  spw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .shift_en (shift_en),
    .bit_i    (pin_lvl[PIN_DATA]),
    .word_o   (word)
  );

  spw_router #(
    .WORD_W (WORD_W), .CTRL_W (CTRL_W), .RDIV_W (RDIV_W),
    .TEST_W (TEST_W), .B_W (B_W), .A_W (A_W)
  ) u_route (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load_i    (le_rise),
    .word_i    (word),
    .ld_prec_o (ld_prec),
    .r_div_o   (r_div),
    .r_err_o   (r_test_err),
    .n_go_o    (n_go),
    .n_b_o     (n_b),
    .n_a_o     (n_a),
    .func_o    (func_word),
    .div_rst_o (div_rst)
  );

  // F1 of the function latch holds the dividers at their load point
  assign cnt_hold = func_word[0];
endmodule

// File: rtl/spw_decoder_chk.sv
module spw_decoder_chk #(
  parameter int WORD_W = 21,
  parameter int RDIV_W = 14,
  parameter int TEST_W = 4,
  parameter int B_W    = 13,
  parameter int A_W    = 5,
  localparam int FIELD_W = WORD_W - 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               le_rise,
  input logic [WORD_W-1:0]  word,
  input logic               ld_prec,
  input logic [RDIV_W-1:0]  r_div,
  input logic               r_test_err,
  input logic               n_go,
  input logic [B_W-1:0]     n_b,
  input logic [A_W-1:0]     n_a,
  input logic [FIELD_W-1:0] func_word,
  input logic               div_rst
);
  a_r2_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word[1:0] == 2'b00) |=> (r_div == $past(word[RDIV_W+1:2])));

  a_r3_n_load: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word[1:0] == 2'b10) |=>
      (n_a == $past(word[A_W+1:2]) && n_b == $past(word[A_W+B_W+1:A_W+2])));

  a_r4_func_load: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word[0]) |=> (func_word == $past(word[WORD_W-1:2])));

  a_r5_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |-> $past(le_rise && word[1:0] == 2'b11));

  a_r5_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |=> !div_rst);

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> ($stable(r_div) && $stable(ld_prec) && $stable(n_b) &&
                  $stable(n_a) && $stable(n_go) && $stable(func_word) &&
                  $stable(r_test_err)));

  a_r6_n_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word[1:0] == 2'b10) |=> ($stable(r_div) && $stable(func_word)));

  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word[1:0] == 2'b00 && word[WORD_W-2 -: TEST_W] != '0) |=> r_test_err);
endmodule

bind spw_decoder spw_decoder_chk #(
  .WORD_W (WORD_W), .RDIV_W (RDIV_W), .TEST_W (TEST_W), .B_W (B_W), .A_W (A_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .le_rise    (le_rise),
  .word       (word),
  .ld_prec    (ld_prec),
  .r_div      (r_div),
  .r_test_err (r_test_err),
  .n_go       (n_go),
  .n_b        (n_b),
  .n_a        (n_a),
  .func_word  (func_word),
  .div_rst    (div_rst)
);

// File: tb/tb_spw_decoder.sv
module tb_spw_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_le = 1'b0;
  logic        ld_prec;
  logic [13:0] r_div;
  logic        r_test_err;
  logic        n_go;
  logic [12:0] n_b;
  logic [4:0]  n_a;
  logic [18:0] func_word;
  logic        cnt_hold;
  logic        div_rst;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  spw_decoder dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .ld_prec(ld_prec), .r_div(r_div), .r_test_err(r_test_err),
    .n_go(n_go), .n_b(n_b), .n_a(n_a), .func_word(func_word),
    .cnt_hold(cnt_hold), .div_rst(div_rst)
  );

  always @(negedge clk) if (div_rst) pulses++;

  // expected state, per requirement
  logic        e_ldp = 0, e_err = 0, e_go = 0;
  logic [13:0] e_rdiv = 0;
  logic [12:0] e_b = 0;
  logic [4:0]  e_a = 0;
  logic [18:0] e_func = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, {31'd0, ld_prec}, {31'd0, e_ldp});
    check(req, {18'd0, r_div}, {18'd0, e_rdiv});
    check(req, {31'd0, r_test_err}, {31'd0, e_err});
    check(req, {31'd0, n_go}, {31'd0, e_go});
    check(req, {19'd0, n_b}, {19'd0, e_b});
    check(req, {27'd0, n_a}, {27'd0, e_a});
    check(req, {13'd0, func_word}, {13'd0, e_func});
    check(req, {31'd0, cnt_hold}, {31'd0, e_func[0]});
  endtask

  task automatic shift_word(logic [20:0] w);
    for (int i = 20; i >= 0; i--) begin
      ser_data = w[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic strobe();
    ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // word = {F19..F1, C1, C2}
  task automatic write_r(logic ldp, logic [3:0] tst, logic [13:0] rv);
    shift_word({ldp, tst, rv, 2'b00});
    check_all("R6 no load before strobe");
    strobe();
    e_ldp = ldp; e_rdiv = rv; e_err = (tst != 0);
  endtask

  task automatic write_n(logic go, logic [12:0] b, logic [4:0] a);
    shift_word({go, b, a, 2'b10});
    check_all("R6 no load before strobe");
    strobe();
    e_go = go; e_b = b; e_a = a;
  endtask

  task automatic write_f(logic [18:0] f, logic init);
    int p0;
    p0 = pulses;
    shift_word({f, init, 1'b1});
    strobe();
    e_func = f;
    if (init) check("R5 one reset pulse", pulses - p0, 1);
    else      check("R5 no pulse on function write", pulses - p0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R8 reset state");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R8 after release");

    // seed every register with a distinct pattern for isolation checks
    write_n(1'b1, 13'h1ACE, 5'h15);  check_all("R3 seed");
    write_f(19'h5A5A5, 1'b0);        check_all("R4 seed");

    // R1 / R2: ratio of 50
    write_r(1'b0, 4'h0, 14'd50);
    check("R1 R=50", {18'd0, r_div}, 32'd50);
    check_all("R2 R6 ratio 50");

    // R2: walking one across the ratio field
    for (int i = 0; i < 14; i++) begin
      write_r(i[0], 4'h0, 14'(1 << i));
      check_all("R2 walk");
    end

    // R7: nonzero test bits flag but still load; clean write clears
    write_r(1'b1, 4'h5, 14'h1234);
    check("R7 flag set", {31'd0, r_test_err}, 32'd1);
    check_all("R7 load despite test bits");
    write_r(1'b0, 4'h8, 14'h3FFF);   check_all("R7 top test bit");
    write_r(1'b0, 4'h0, 14'h0ABC);
    check("R7 flag cleared", {31'd0, r_test_err}, 32'd0);

    // R3: every A against computed B
    for (int a = 0; a < 32; a++) begin
      write_n(a[0], 13'((a * 211 + 3) & 13'h1FFF), 5'(a));
      check_all("R3 R6 n sweep");
    end

    // R4 / R5: function and init latches
    for (int k = 0; k < 8; k++) begin
      write_f(19'((k * 19'h2A5B3) ^ (k << 3) ^ k), 1'b0);
      check_all("R4 R6 func sweep");
    end
    for (int k = 0; k < 4; k++) begin
      write_f(19'((k + 1) * 19'h11111 + k), 1'b1);
      check_all("R5 R6 init sweep");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule